// File: doc/BRIEF.md
# Floating-Point Load/Store Address Unit

This block decodes one 32-bit instruction word per cycle and sorts out the floating-point memory instructions: loads and stores of single and double precision, plus the store of a register's low integer word. It handles both the displacement form (16-bit signed offset) and the register-indexed form, each with and without a base update. For a recognised instruction it reports the floating-point register index, the effective address, the access kind, the direction and whether the base register is updated. Everything else is flagged illegal. That includes the arithmetic floating-point opcodes, which this unit does not handle.

The integer register file sits outside the block and is read through two combinational read ports. The index of each port is driven straight from the instruction fields. The memory access itself happens elsewhere. A base-update instruction parks its writeback (register index and address) in a pending slot. The integer register write is issued only once the downstream operation reports completion with no trap. A trap drops the pending update.

A base-register field of zero does not mean the same thing in every form. In the plain displacement form it stands for a zero base. In the displacement-update form it is illegal. In the plain indexed form it is illegal, except for the integer-word store, which then uses the index register alone. In the indexed-update form it is a zero base, and the update targets register 0.

Top module: `fpls_eau`

## Requirements
- R1: With primary opcode (bits 31:26) from 48 to 55, the offset from 48 selects the operation. Offset bit 0 means base update, bit 1 means double, and bit 2 means store. The kind encoding is 2'b00 single, 2'b01 double and 2'b10 integer word, and out_store is 1 for a store.
- R2: With primary opcode 31, the extended opcode in bits 10:1 selects the operation. Values 535, 567, 599, 631, 663, 695, 727 and 759 map like offsets 0 to 7 of R1, in indexed form. Value 983 is the integer-word store: kind 2'b10, store, no update.
- R3: out_fpr is bits 25:21. gpr_a_idx is bits 20:16 and gpr_b_idx is bits 15:11, both taken from the incoming word in the same cycle. The displacement is bits 15:0, sign-extended.
- R4: In the non-update displacement form, EA = sext(disp) + GPR[RA], where an RA of 0 contributes zero. In the displacement-update form, EA = GPR[RA] + sext(disp).
- R5: In the displacement-update form, an RA of 0 sets out_illegal.
- R6: In the non-update indexed form, an RA of 0 sets out_illegal, except for the integer-word store. That instruction then has EA = GPR[RB]. With a nonzero RA, EA = GPR[RA] + GPR[RB].
- R7: In the indexed-update form, an RA of 0 is legal and gives EA = GPR[RB], with the update targeting register 0. A nonzero RA gives GPR[RA] + GPR[RB].
- R8: Any other primary opcode, or any other extended opcode under 31, sets out_illegal. This includes the arithmetic floating-point opcodes 59 and 63. An illegal result never has out_update set and never arms a writeback.
- R9: The outputs are registered. out_valid is high for exactly the one cycle after each cycle in which insn_valid was high.
- R10: out_next_pc is pc_in + 4 for a legal instruction and pc_in unchanged for an illegal one.
- R11: A legal update instruction arms a pending writeback. wb_en pulses for one cycle in the cycle after op_done is seen high with op_trap low, carrying wb_idx = RA and wb_data = EA. op_done with op_trap high discards the pending writeback, and wb_en stays low.
- R12: After reset, out_valid and wb_en are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | Instruction word |
| pc_in | input | XLEN | Address of the instruction |
| gpr_a_idx | output | 5 | Register file port A index (RA field) |
| gpr_a_data | input | XLEN | Register file port A data |
| gpr_b_idx | output | 5 | Register file port B index (RB field) |
| gpr_b_data | input | XLEN | Register file port B data |
| op_done | input | 1 | Downstream operation outcome known |
| op_trap | input | 1 | Outcome was a trap (valid with op_done) |
| out_valid | output | 1 | Registered result valid |
| out_illegal | output | 1 | Instruction not handled |
| out_fpr | output | 5 | Floating-point register index |
| out_ea | output | XLEN | Effective address |
| out_kind | output | 2 | 00 single, 01 double, 10 integer word |
| out_store | output | 1 | 1 store, 0 load |
| out_update | output | 1 | Base-update instruction |
| out_next_pc | output | XLEN | Program counter after this instruction |
| wb_en | output | 1 | Base-register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | XLEN | Writeback value (the EA) |

## Verification
Assertions check on every cycle that the result strobe follows the instruction strobe by one cycle. They also check that a legal result advances the program counter by four, that an illegal result never claims an update, that a displacement-update result never has a zero base field, and that the writeback strobe appears only after a clean completion of a pending update, never after a trap. The address arithmetic for each form and the full opcode map are shown only by the bench's sweeps. Those sweeps cover every primary opcode and every extended opcode with both a zero and a nonzero base field, and compare against addresses computed from a model register file. The bench scenarios also show the writeback carrying the right index and address, and a trap dropping the update for good.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

    localparam int REG_IDX_W  = 5;
    localparam int DISP_W     = 16;
    localparam int PC_STEP    = 4;

    localparam logic [5:0] OPC_INDEXED  = 6'd31;
    localparam logic [5:0] OPC_MEM_BASE = 6'd48;
    localparam logic [5:0] OPC_MEM_LAST = 6'd55;
    localparam logic [9:0] XO_IWORD_ST  = 10'd983;

    typedef enum logic [1:0] {
        KIND_SGL = 2'b00,
        KIND_DBL = 2'b01,
        KIND_IWD = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic      legal;
        logic      indexed;
        logic      update;
        logic      is_store;
        acc_kind_e kind;
    } dec_t;

    // Three-bit selector shared by both forms: bit0 update, bit1 double, bit2 store
    function automatic dec_t from_sel(input logic [2:0] sel, input logic indexed);
        dec_t d;
        d.legal    = 1'b1;
        d.indexed  = indexed;
        d.update   = sel[0];
        d.kind     = sel[1] ? KIND_DBL : KIND_SGL;
        d.is_store = sel[2];
        return d;
    endfunction

endpackage

// File: rtl/fpls_decode.sv
module fpls_decode
    import fpls_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic [5:0] primary;
    logic [9:0] xo;
    logic [5:0] mem_off;
    logic       ra_zero;
    dec_t       raw;

    assign primary = insn[31:26];
    assign xo      = insn[10:1];
    assign mem_off = primary - OPC_MEM_BASE;
    assign ra_zero = (insn[20:16] == '0);

    always_comb begin
        raw = '0;
        if (primary >= OPC_MEM_BASE && primary <= OPC_MEM_LAST) begin
            raw = from_sel(mem_off[2:0], 1'b0);
        end else if (primary == OPC_INDEXED) begin
            if (xo == XO_IWORD_ST) begin
                raw.legal    = 1'b1;
                raw.indexed  = 1'b1;
                raw.update   = 1'b0;
                raw.is_store = 1'b1;
                raw.kind     = KIND_IWD;
            end else if (xo[9:8] == 2'b10 && xo[4:0] == 5'b10111) begin
                raw = from_sel(xo[7:5], 1'b1);
            end
        end
    end

    // Zero base-field legality differs per addressing form
    always_comb begin
        dec = raw;
        if (raw.legal && ra_zero) begin
            if (!raw.indexed && raw.update)
                dec.legal = 1'b0;
            else if (raw.indexed && !raw.update && raw.kind != KIND_IWD)
                dec.legal = 1'b0;
        end
        if (!dec.legal)
            dec.update = 1'b0;
    end

endmodule

// File: rtl/fpls_agen.sv
module fpls_agen
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              base_zero,
    input  logic [XLEN-1:0]   base_val,
    input  logic              use_index,
    input  logic [XLEN-1:0]   index_val,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   ea
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] disp_ext;

    assign disp_ext = XLEN'($signed(disp));
    assign base     = base_zero ? '0 : base_val;
    assign offset   = use_index ? index_val : disp_ext;
    assign ea       = base + offset;

endmodule

// File: rtl/fpls_commit.sv
module fpls_commit
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm,
    input  logic [REG_IDX_W-1:0] arm_idx,
    input  logic [XLEN-1:0]      arm_ea,
    input  logic                 op_done,
    input  logic                 op_trap,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]      wb_data
);
    logic                 pend_q;
    logic [REG_IDX_W-1:0] pend_idx_q;
    logic [XLEN-1:0]      pend_ea_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            pend_ea_q  <= '0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_data    <= '0;
        end else begin
            wb_en <= pend_q && op_done && !op_trap;
            if (pend_q && op_done) begin
                wb_idx  <= pend_idx_q;
                wb_data <= pend_ea_q;
            end
            if (op_done)
                pend_q <= 1'b0;
            if (arm) begin
                pend_q     <= 1'b1;
                pend_idx_q <= arm_idx;
                pend_ea_q  <= arm_ea;
            end
        end
    end

    // R11: writeback strobe only after a clean completion
    a_r11_wb_needs_clean_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(op_done && !op_trap));

    // R11: a trapped completion never produces a writeback
    a_r11_trap_blocks_wb: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_trap) |=> !wb_en);

    // R11: writeback only from an armed slot
    a_r11_wb_from_pending: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(pend_q));

endmodule

// File: rtl/fpls_eau.sv
module fpls_eau
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 insn_valid,
    input  logic [31:0]          insn,
    input  logic [XLEN-1:0]      pc_in,
    output logic [REG_IDX_W-1:0] gpr_a_idx,
    input  logic [XLEN-1:0]      gpr_a_data,
    output logic [REG_IDX_W-1:0] gpr_b_idx,
    input  logic [XLEN-1:0]      gpr_b_data,
    input  logic                 op_done,
    input  logic                 op_trap,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [REG_IDX_W-1:0] out_fpr,
    output logic [XLEN-1:0]      out_ea,
    output logic [1:0]           out_kind,
    output logic                 out_store,
    output logic                 out_update,
    output logic [XLEN-1:0]      out_next_pc,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]      wb_data
);
    dec_t            dec;
    logic [XLEN-1:0] ea_c;
    logic            ra_zero;

    assign gpr_a_idx = insn[20:16];
    assign gpr_b_idx = insn[15:11];
    assign ra_zero   = (insn[20:16] == '0);

    fpls_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    fpls_agen #(.XLEN(XLEN)) u_agen (
        .base_zero (ra_zero),
        .base_val  (gpr_a_data),
        .use_index (dec.indexed),
        .index_val (gpr_b_data),
        .disp      (insn[15:0]),
        .ea        (ea_c)
    );

    fpls_commit #(.XLEN(XLEN)) u_cmt (
        .clk     (clk),
        .rst     (rst),
        .arm     (insn_valid && dec.legal && dec.update),
        .arm_idx (insn[20:16]),
        .arm_ea  (ea_c),
        .op_done (op_done),
        .op_trap (op_trap),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (wb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_fpr     <= '0;
            out_ea      <= '0;
            out_kind    <= KIND_SGL;
            out_store   <= 1'b0;
            out_update  <= 1'b0;
            out_next_pc <= '0;
        end else begin
            out_valid <= insn_valid;
            if (insn_valid) begin
                out_illegal <= !dec.legal;
                out_fpr     <= insn[25:21];
                out_ea      <= ea_c;
                out_kind    <= dec.kind;
                out_store   <= dec.is_store;
                out_update  <= dec.update;
                out_next_pc <= dec.legal ? pc_in + XLEN'(PC_STEP) : pc_in;
            end
        end
    end

    // R9: result strobe follows the instruction strobe by one cycle
    a_r9_valid_follows_insn: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(insn_valid));

    // R10: a legal instruction advances the program counter by four
    a_r10_pc_advance: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> (out_next_pc == $past(pc_in) + XLEN'(PC_STEP)));

    // R8: illegal results never claim an update
    a_r8_illegal_no_update: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> !out_update);

    // R5: a legal displacement-update result never had a zero base field
    a_r5_disp_upd_base_nonzero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_update && $past(insn[31:26] != OPC_INDEXED))
            |-> $past(insn[20:16] != 5'd0));

endmodule

// File: tb/fpls_eau_tb.sv
`timescale 1ns/1ps
module fpls_eau_tb;
    localparam int XLEN = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             insn_valid = 1'b0;
    logic [31:0]      insn = '0;
    logic [XLEN-1:0]  pc_in = '0;
    logic [4:0]       gpr_a_idx, gpr_b_idx;
    logic [XLEN-1:0]  gpr_a_data, gpr_b_data;
    logic             op_done = 1'b0;
    logic             op_trap = 1'b0;
    logic             out_valid, out_illegal, out_store, out_update;
    logic [4:0]       out_fpr;
    logic [XLEN-1:0]  out_ea, out_next_pc;
    logic [1:0]       out_kind;
    logic             wb_en;
    logic [4:0]       wb_idx;
    logic [XLEN-1:0]  wb_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] gval(input logic [4:0] i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h00F0_1234);
    endfunction

    assign gpr_a_data = gval(gpr_a_idx);
    assign gpr_b_data = gval(gpr_b_idx);

    fpls_eau #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .pc_in(pc_in),
        .gpr_a_idx(gpr_a_idx), .gpr_a_data(gpr_a_data),
        .gpr_b_idx(gpr_b_idx), .gpr_b_data(gpr_b_data),
        .op_done(op_done), .op_trap(op_trap),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_fpr(out_fpr),
        .out_ea(out_ea), .out_kind(out_kind), .out_store(out_store),
        .out_update(out_update), .out_next_pc(out_next_pc),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h insn=%h", tag, act, exp, insn);
        end
    endtask

    // Expected behaviour from the requirements
    task automatic model(input logic [31:0] w, output bit ill, output bit [1:0] kind,
                         output bit st, output bit up, output logic [31:0] ea);
        bit known, ix;
        int sel;
        logic [4:0] ra, rb;
        logic [31:0] base;
        ra = w[20:16]; rb = w[15:11];
        known = 0; ix = 0; sel = 0; kind = 0; st = 0; up = 0;
        if (w[31:26] >= 48 && w[31:26] <= 55) begin
            known = 1; sel = int'(w[31:26]) - 48;
        end else if (w[31:26] == 31) begin
            case (int'(w[10:1]))
                535: begin known = 1; sel = 0; end
                567: begin known = 1; sel = 1; end
                599: begin known = 1; sel = 2; end
                631: begin known = 1; sel = 3; end
                663: begin known = 1; sel = 4; end
                695: begin known = 1; sel = 5; end
                727: begin known = 1; sel = 6; end
                759: begin known = 1; sel = 7; end
                983: begin known = 1; sel = 4; end
                default: known = 0;
            endcase
            ix = 1;
        end
        up   = (sel % 2) == 1;
        kind = ((sel / 2) % 2 == 1) ? 2'b01 : 2'b00;
        st   = sel >= 4;
        if (ix && int'(w[10:1]) == 983) kind = 2'b10;
        base = (ra == 0) ? 32'd0 : gval(ra);
        if (!ix) ea = base + {{16{w[15]}}, w[15:0]};
        else     ea = base + gval(rb);
        ill = !known;
        if (known && !ix && up && ra == 0) ill = 1;
        if (known && ix && !up && ra == 0 && kind != 2'b10) ill = 1;
        if (ill) up = 0;
    endtask

    task automatic run(input logic [31:0] w, input logic [31:0] pc);
        bit ill, st, up;
        bit [1:0] kind;
        logic [31:0] ea;
        model(w, ill, kind, st, up, ea);
        @(negedge clk);
        insn = w; pc_in = pc; insn_valid = 1'b1;
        #1;
        chk("R3 port A index", 64'(gpr_a_idx), 64'(w[20:16]));
        chk("R3 port B index", 64'(gpr_b_idx), 64'(w[15:11]));
        @(negedge clk);
        insn_valid = 1'b0;
        chk("R9 out_valid", 64'(out_valid), 64'd1);
        chk("R5/R6/R8 illegal", 64'(out_illegal), 64'(ill));
        chk("R10 next_pc", 64'(out_next_pc), 64'(ill ? pc : pc + 32'd4));
        chk("R8 update", 64'(out_update), 64'(up));
        if (!ill) begin
            chk("R3 fpr", 64'(out_fpr), 64'(w[25:21]));
            chk("R1/R2 kind", 64'(out_kind), 64'(kind));
            chk("R1/R2 store", 64'(out_store), 64'(st));
            chk("R4/R6/R7 ea", 64'(out_ea), 64'(ea));
        end
        @(negedge clk);
        chk("R9 single pulse", 64'(out_valid), 64'd0);
    endtask

    task automatic resolve(input bit trap, input bit exp_wb, input logic [4:0] idx,
                           input logic [31:0] data);
        @(negedge clk);
        op_done = 1'b1; op_trap = trap;
        @(negedge clk);
        op_done = 1'b0; op_trap = 1'b0;
        chk("R11 wb_en", 64'(wb_en), 64'(exp_wb));
        if (exp_wb) begin
            chk("R11 wb_idx", 64'(wb_idx), 64'(idx));
            chk("R11 wb_data", 64'(wb_data), 64'(data));
        end
        @(negedge clk);
        chk("R11 wb pulse ends", 64'(wb_en), 64'd0);
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset out_valid", 64'(out_valid), 64'd0);
        chk("R12 reset wb_en", 64'(wb_en), 64'd0);
        rst = 1'b0;

        // Primary opcode sweep, zero and nonzero base, negative and positive offsets
        for (int op = 0; op < 64; op++) begin
            for (int r = 0; r < 2; r++) begin
                logic [15:0] d;
                d = (op % 2 == 0) ? 16'hFFF0 : 16'h0124;
                run({6'(op), 5'(op ^ 3), (r == 0) ? 5'd0 : 5'd9, d}, 32'h0000_1000 + 32'(op * 8));
            end
        end

        // Extended opcode sweep under 31
        for (int xo = 0; xo < 1024; xo++) begin
            for (int r = 0; r < 2; r++) begin
                run({6'd31, 5'd21, (r == 0) ? 5'd0 : 5'd6, 5'd13, 10'(xo), 1'(xo)},
                    32'h0002_0000 + 32'(xo * 4));
            end
        end

        // R11: displacement update, clean completion
        run({6'd49, 5'd2, 5'd4, 16'h0008}, 32'h100);
        resolve(1'b0, 1'b1, 5'd4, gval(5'd4) + 32'd8);

        // R7 with R11: indexed update, zero base, writeback targets register 0
        run({6'd31, 5'd1, 5'd0, 5'd11, 10'd759, 1'b0}, 32'h200);
        resolve(1'b0, 1'b1, 5'd0, gval(5'd11));

        // R11: trap drops the update, later completion does nothing
        run({6'd55, 5'd3, 5'd7, 16'h8000}, 32'h300);
        resolve(1'b1, 1'b0, 5'd0, 32'd0);
        resolve(1'b0, 1'b0, 5'd0, 32'd0);

        // R8: illegal update form arms nothing
        run({6'd51, 5'd3, 5'd0, 16'h0010}, 32'h400);
        resolve(1'b0, 1'b0, 5'd0, 32'd0);

        // R11: non-update instruction arms nothing
        run({6'd50, 5'd3, 5'd5, 16'h0010}, 32'h500);
        resolve(1'b0, 1'b0, 5'd0, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule